// File: doc/BRIEF.md
# Aliased Floating-Point Register File

This block is the storage for a floating-point unit's registers. A single array of 64-bit double-width cells can be reached at three widths: 32-bit single, 64-bit double and 128-bit quad. Each of its three ports carries a 2-bit size code, and the port decodes its 5-bit register field according to that code. Two read ports are combinational and return data right-aligned on a 128-bit bus, with the unused upper bits zero. One write port commits on the rising clock edge.

The array holds 32 doubles. The lower 16 form the base bank, where every double splits into two singles and every even/odd pair of doubles forms one quad. The upper 16 form the extended bank. The `ext_mode` input makes the extended bank reachable, and only at double or quad width. A port whose register field does not align to the requested width, or whose size code is reserved, raises its error flag. A write with such an error leaves the array untouched.

Top module: `fprf_alias_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, every cell is cleared, so any read that follows returns zero.
- R2: Size code 2'b00 selects a single. Single field s maps to double s>>1. An even s occupies bits 63:32 of that double and an odd s occupies bits 31:0. A single read returns the value in bits 31:0 with bits 127:32 zero.
- R3: A single write changes only its own 32-bit half. The other half of the containing double keeps its value.
- R4: Size code 2'b01 selects a double. A double read returns the 64-bit value in bits 63:0 with bits 127:64 zero.
- R5: Size code 2'b10 selects a quad made of two consecutive doubles d and d+1. Double d sits in bits 127:64 and double d+1 sits in bits 63:0.
- R6: With `ext_mode` low, a double field f addresses double f>>1. An odd f raises the port's error flag, reads back as zero, and is not written.
- R7: With `ext_mode` low, a quad field f that is not a multiple of 4 raises the error flag, reads back as zero, and is not written.
- R8: With `ext_mode` high, a double field f addresses double {f[0], f[4:1]}, so odd fields reach doubles 16 to 31.
- R9: With `ext_mode` high, a quad field f uses first double {f[0], f[4:1]}. It is misaligned exactly when f[1] is set.
- R10: A single access always lands in the base bank, whatever the state of `ext_mode`. Single field 31 is the lower half of double 15.
- R11: Size code 2'b11 is reserved. It raises the error flag, reads back as zero, and is not written.
- R12: A read returns the contents as they stood before the current edge, even when the same cycle writes the location. The two read ports work independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_mode | input | 1 | Enables the extended bank for double and quad decode |
| rd0_size | input | 2 | Read port 0 width code |
| rd0_idx | input | 5 | Read port 0 register field |
| rd0_data | output | 128 | Read port 0 data, right-aligned |
| rd0_err | output | 1 | Read port 0 misalignment or reserved size |
| rd1_size | input | 2 | Read port 1 width code |
| rd1_idx | input | 5 | Read port 1 register field |
| rd1_data | output | 128 | Read port 1 data, right-aligned |
| rd1_err | output | 1 | Read port 1 misalignment or reserved size |
| wr_en | input | 1 | Write enable |
| wr_size | input | 2 | Write width code |
| wr_idx | input | 5 | Write register field |
| wr_data | input | 128 | Write data, right-aligned |
| wr_err | output | 1 | Write requested with a misaligned field or reserved size |

## Verification
Read data and all three error flags are combinational. They are due in the same cycle the port inputs are applied. The bench drives each vector just after a falling edge and samples one time unit later, before the next rising edge. A write becomes visible only after the next rising edge, so every vector that follows a write reads the array in the cycle after the commit. The vector in the same cycle as the write reads the old value, which is how R12 is checked. A reset pulse lasting one edge is checked by reading in the cycle after that edge.

// File: rtl/fprf_pkg.sv
// Shared constants and types for the aliased floating-point register file.
// Assumes a 5-bit register field and 64-bit double cells as the storage unit.
package fprf_pkg;
    localparam int FP_IDX_W    = 5;
    localparam int FP_SGL_W    = 32;
    localparam int FP_DBL_W    = 2 * FP_SGL_W;
    localparam int FP_BUS_W    = 2 * FP_DBL_W;
    localparam int FP_BASE_DBL = 16;
    localparam int FP_EXT_DBL  = 16;
    localparam int FP_TOT_DBL  = FP_BASE_DBL + FP_EXT_DBL;
    localparam int FP_DIDX_W   = $clog2(FP_TOT_DBL);

    typedef enum logic [1:0] {
        SZ_SGL  = 2'b00,
        SZ_DBL  = 2'b01,
        SZ_QUAD = 2'b10,
        SZ_RSV  = 2'b11
    } fp_size_e;

    // Decoded location of one port access.
    typedef struct packed {
        logic                 bad;
        fp_size_e             size;
        logic [FP_DIDX_W-1:0] dbl;
        logic                 lo_half;
    } fp_loc_t;
endpackage

// File: rtl/fprf_decode.sv
// Turns a size code and register field into a double-cell location.
// Assumes IDX_W equals the double-index width, so the extended-mode swap
// of the low field bit into the top address bit fills the whole index.
module fprf_decode
    import fprf_pkg::*;
#(
    parameter int IDX_W = FP_IDX_W
) (
    input  logic             ext_mode,
    input  logic [1:0]       size,
    input  logic [IDX_W-1:0] idx,
    output fp_loc_t          loc
);
    localparam int DW = FP_DIDX_W;

    // Decode the field according to width and bank mode.
    always_comb begin
        loc      = '0;
        loc.size = fp_size_e'(size);
        unique case (fp_size_e'(size))
            SZ_SGL: begin
                loc.dbl     = DW'(idx[IDX_W-1:1]);
                loc.lo_half = idx[0];
            end
            SZ_DBL: begin
                if (ext_mode) begin
                    loc.dbl = DW'({idx[0], idx[IDX_W-1:1]});
                end else begin
                    loc.dbl = DW'(idx[IDX_W-1:1]);
                    loc.bad = idx[0];
                end
            end
            SZ_QUAD: begin
                if (ext_mode) begin
                    loc.dbl = DW'({idx[0], idx[IDX_W-1:1]});
                    loc.bad = idx[1];
                end else begin
                    loc.dbl = DW'(idx[IDX_W-1:1]);
                    loc.bad = |idx[1:0];
                end
            end
            default: loc.bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/fprf_store.sv
// Array of double cells with one write port that can update a half,
// a whole cell, or a pair of cells. Assumes the location is pre-decoded
// and that a quad's first double is even, so d+1 never wraps.
module fprf_store
    import fprf_pkg::*;
#(
    parameter int NUM_DBL = FP_TOT_DBL,
    parameter int DBL_W   = FP_DBL_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  fp_loc_t                       wloc,
    input  logic [2*DBL_W-1:0]            wdata,
    output logic [NUM_DBL-1:0][DBL_W-1:0] mem_q
);
    localparam int HALF_W = DBL_W / 2;
    localparam int DW     = FP_DIDX_W;

    logic commit;
    logic [DW-1:0] next_dbl;

    // Qualify the write and form the second cell of a quad.
    always_comb begin
        commit   = we && !wloc.bad;
        next_dbl = wloc.dbl + DW'(1);
    end

    for (genvar g = 0; g < NUM_DBL; g++) begin : g_cell
        logic [DBL_W-1:0] cell_q;

        // Update this cell when the decoded write targets it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else if (commit) begin
                unique case (wloc.size)
                    SZ_SGL: begin
                        if (wloc.dbl == DW'(g)) begin
                            if (wloc.lo_half) cell_q[HALF_W-1:0]     <= wdata[HALF_W-1:0];
                            else              cell_q[DBL_W-1:HALF_W] <= wdata[HALF_W-1:0];
                        end
                    end
                    SZ_DBL: begin
                        if (wloc.dbl == DW'(g)) cell_q <= wdata[DBL_W-1:0];
                    end
                    SZ_QUAD: begin
                        if (wloc.dbl == DW'(g))      cell_q <= wdata[2*DBL_W-1:DBL_W];
                        else if (next_dbl == DW'(g)) cell_q <= wdata[DBL_W-1:0];
                    end
                    default: ;
                endcase
            end
        end

        assign mem_q[g] = cell_q;
    end
endmodule

// File: rtl/fprf_rdmux.sv
// Combinational read selector for one port. It right-aligns the selected
// half, cell or cell pair on the output bus. Returns zero on a bad location.
module fprf_rdmux
    import fprf_pkg::*;
#(
    parameter int NUM_DBL = FP_TOT_DBL,
    parameter int DBL_W   = FP_DBL_W
) (
    input  fp_loc_t                       loc,
    input  logic [NUM_DBL-1:0][DBL_W-1:0] mem_q,
    output logic [2*DBL_W-1:0]            data
);
    localparam int HALF_W = DBL_W / 2;
    localparam int DW     = FP_DIDX_W;

    logic [DBL_W-1:0] first_c;
    logic [DBL_W-1:0] second_c;

    // Pick the addressed cell and its successor.
    always_comb begin
        first_c  = mem_q[loc.dbl];
        second_c = mem_q[loc.dbl + DW'(1)];
    end

    // Align the result according to the access width.
    always_comb begin
        data = '0;
        if (!loc.bad) begin
            unique case (loc.size)
                SZ_SGL:  data[HALF_W-1:0] = loc.lo_half ? first_c[HALF_W-1:0]
                                                        : first_c[DBL_W-1:HALF_W];
                SZ_DBL:  data[DBL_W-1:0]  = first_c;
                SZ_QUAD: data             = {first_c, second_c};
                default: data             = '0;
            endcase
        end
    end
endmodule

// File: rtl/fprf_alias_top.sv
// Top of the aliased register file: two combinational read ports and one
// clocked write port over one shared array of double cells.
// Assumes all ports see the same bank mode in a given cycle.
module fprf_alias_top
    import fprf_pkg::*;
#(
    parameter int NUM_DBL = FP_TOT_DBL,
    parameter int IDX_W   = FP_IDX_W,
    parameter int BUS_W   = FP_BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_mode,
    input  logic [1:0]       rd0_size,
    input  logic [IDX_W-1:0] rd0_idx,
    output logic [BUS_W-1:0] rd0_data,
    output logic             rd0_err,
    input  logic [1:0]       rd1_size,
    input  logic [IDX_W-1:0] rd1_idx,
    output logic [BUS_W-1:0] rd1_data,
    output logic             rd1_err,
    input  logic             wr_en,
    input  logic [1:0]       wr_size,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [BUS_W-1:0] wr_data,
    output logic             wr_err
);
    localparam int NUM_RD = 2;
    localparam int DBL_W  = BUS_W / 2;

    logic [NUM_DBL-1:0][DBL_W-1:0] mem_q;
    fp_loc_t                       wloc;
    logic [1:0]                    rsize [NUM_RD];
    logic [IDX_W-1:0]              ridx  [NUM_RD];
    fp_loc_t                       rloc  [NUM_RD];
    logic [BUS_W-1:0]              rdata [NUM_RD];

    // Gather the read port inputs into arrays.
    always_comb begin
        rsize[0] = rd0_size;
        rsize[1] = rd1_size;
        ridx[0]  = rd0_idx;
        ridx[1]  = rd1_idx;
    end

    fprf_decode #(.IDX_W(IDX_W)) u_wdec (
        .ext_mode (ext_mode),
        .size     (wr_size),
        .idx      (wr_idx),
        .loc      (wloc)
    );

    fprf_store #(.NUM_DBL(NUM_DBL), .DBL_W(DBL_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .wloc  (wloc),
        .wdata (wr_data),
        .mem_q (mem_q)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        fprf_decode #(.IDX_W(IDX_W)) u_rdec (
            .ext_mode (ext_mode),
            .size     (rsize[p]),
            .idx      (ridx[p]),
            .loc      (rloc[p])
        );

        fprf_rdmux #(.NUM_DBL(NUM_DBL), .DBL_W(DBL_W)) u_rmux (
            .loc   (rloc[p]),
            .mem_q (mem_q),
            .data  (rdata[p])
        );
    end

    // Drive the port outputs and the error flags.
    always_comb begin
        rd0_data = rdata[0];
        rd1_data = rdata[1];
        rd0_err  = rloc[0].bad;
        rd1_err  = rloc[1].bad;
        wr_err   = wr_en && wloc.bad;
    end
endmodule

// File: rtl/fprf_alias_chk.sv
// Property checker attached to the register file top. It observes the ports
// and the shared cell array only.
module fprf_alias_chk
    import fprf_pkg::*;
#(
    parameter int NUM_DBL = FP_TOT_DBL,
    parameter int IDX_W   = FP_IDX_W,
    parameter int BUS_W   = FP_BUS_W
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic [1:0]                          rd0_size,
    input logic [BUS_W-1:0]                    rd0_data,
    input logic                                rd0_err,
    input logic                                wr_en,
    input logic [1:0]                          wr_size,
    input logic [IDX_W-1:0]                    wr_idx,
    input logic                                wr_err,
    input logic [NUM_DBL-1:0][BUS_W/2-1:0]     mem_q
);
    localparam int DBL_W = BUS_W / 2;
    localparam int HW    = DBL_W / 2;

    // R1
    reset_clears_chk: assert property (@(posedge clk) !rst_n |=> (mem_q == '0));

    // R2
    single_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_size == 2'b00) |-> (rd0_data[BUS_W-1:HW] == '0));

    // R4
    double_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_size == 2'b01) |-> (rd0_data[BUS_W-1:DBL_W] == '0));

    // R11
    reserved_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_size == 2'b11) |-> (rd0_err && rd0_data == '0));

    // R6
    bad_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> $stable(mem_q));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mem_q));

    // R10
    single_base_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 2'b00) |=> $stable(mem_q[NUM_DBL-1:NUM_DBL/2]));

    // R3
    single_even_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 2'b00 && !wr_idx[0]) |=>
        (mem_q[$past(wr_idx[IDX_W-1:1])][HW-1:0] == $past(mem_q[wr_idx[IDX_W-1:1]][HW-1:0])));
endmodule

bind fprf_alias_top fprf_alias_chk #(
    .NUM_DBL (NUM_DBL),
    .IDX_W   (IDX_W),
    .BUS_W   (BUS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd0_size (rd0_size),
    .rd0_data (rd0_data),
    .rd0_err  (rd0_err),
    .wr_en    (wr_en),
    .wr_size  (wr_size),
    .wr_idx   (wr_idx),
    .wr_err   (wr_err),
    .mem_q    (mem_q)
);

// File: tb/fprf_alias_top_tb_top.sv
// Self-checking bench: a vector table walked once, then directed checks
// for the second read port and for reset.
module fprf_alias_top_tb_top;
    localparam int CLK_T = 10;
    localparam int NV    = 28;

    typedef struct packed {
        logic         ext;
        logic         wen;
        logic [1:0]   wsz;
        logic [4:0]   widx;
        logic [127:0] wdat;
        logic [1:0]   rsz;
        logic [4:0]   ridx;
        logic [127:0] exp_d;
        logic         exp_re;
        logic         exp_we;
        logic [3:0]   req;
    } vec_t;

    // Fields: ext, wen, wsz, widx, wdat, rsz, ridx, exp data, exp rd err, exp wr err, req
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 2'd0, 5'd0,  128'hAAAA0001, 2'd1, 5'd0, 128'h0, 1'b0, 1'b0, 4'd12},                   // R12
        '{1'b0, 1'b1, 2'd0, 5'd1,  128'hBBBB0002, 2'd1, 5'd0, 128'hAAAA0001_00000000, 1'b0, 1'b0, 4'd2},    // R2
        '{1'b0, 1'b0, 2'd0, 5'd0,  128'h0, 2'd1, 5'd0, 128'hAAAA0001_BBBB0002, 1'b0, 1'b0, 4'd3},           // R3
        '{1'b0, 1'b1, 2'd0, 5'd0,  128'h11110000, 2'd0, 5'd1, 128'hBBBB0002, 1'b0, 1'b0, 4'd2},             // R2
        '{1'b0, 1'b0, 2'd0, 5'd0,  128'h0, 2'd1, 5'd0, 128'h11110000_BBBB0002, 1'b0, 1'b0, 4'd3},           // R3
        '{1'b0, 1'b1, 2'd1, 5'd2,  128'hFFFF_0123456789ABCDEF, 2'd0, 5'd2, 128'h0, 1'b0, 1'b0, 4'd12},      // R12
        '{1'b0, 1'b0, 2'd0, 5'd0,  128'h0, 2'd1, 5'd2, 128'h0123456789ABCDEF, 1'b0, 1'b0, 4'd4},            // R4
        '{1'b0, 1'b0, 2'd0, 5'd0,  128'h0, 2'd0, 5'd3, 128'h89ABCDEF, 1'b0, 1'b0, 4'd2},                    // R2
        '{1'b0, 1'b0, 2'd0, 5'd0,  128'h0, 2'd2, 5'd0, 128'h11110000BBBB0002_0123456789ABCDEF, 1'b0, 1'b0, 4'd5}, // R5
        '{1'b0, 1'b1, 2'd2, 5'd4,  128'h22222222_33333333_44444444_55555555, 2'd1, 5'd6, 128'h0, 1'b0, 1'b0, 4'd12}, // R12
        '{1'b0, 1'b0, 2'd0, 5'd0,  128'h0, 2'd1, 5'd4, 128'h22222222_33333333, 1'b0, 1'b0, 4'd5},           // R5
        '{1'b0, 1'b0, 2'd0, 5'd0,  128'h0, 2'd1, 5'd6, 128'h44444444_55555555, 1'b0, 1'b0, 4'd5},           // R5
        '{1'b0, 1'b1, 2'd1, 5'd3,  {128{1'b1}}, 2'd1, 5'd3, 128'h0, 1'b1, 1'b1, 4'd6},                      // R6
        '{1'b0, 1'b0, 2'd0, 5'd0,  128'h0, 2'd1, 5'd2, 128'h0123456789ABCDEF, 1'b0, 1'b0, 4'd6},            // R6
        '{1'b0, 1'b1, 2'd2, 5'd2,  {128{1'b1}}, 2'd2, 5'd2, 128'h0, 1'b1, 1'b1, 4'd7},                      // R7
        '{1'b0, 1'b0, 2'd0, 5'd0,  128'h0, 2'd2, 5'd0, 128'h11110000BBBB0002_0123456789ABCDEF, 1'b0, 1'b0, 4'd7}, // R7
        '{1'b1, 1'b1, 2'd1, 5'd1,  128'hEEEE0000_DDDD0000, 2'd1, 5'd1, 128'h0, 1'b0, 1'b0, 4'd8},           // R8
        '{1'b1, 1'b0, 2'd0, 5'd0,  128'h0, 2'd1, 5'd1, 128'hEEEE0000_DDDD0000, 1'b0, 1'b0, 4'd8},           // R8
        '{1'b1, 1'b0, 2'd0, 5'd0,  128'h0, 2'd1, 5'd0, 128'h11110000_BBBB0002, 1'b0, 1'b0, 4'd8},           // R8
        '{1'b1, 1'b0, 2'd0, 5'd0,  128'h0, 2'd2, 5'd1, 128'hEEEE0000DDDD0000_0000000000000000, 1'b0, 1'b0, 4'd9}, // R9
        '{1'b1, 1'b1, 2'd2, 5'd5,  128'h66666666_77777777_88888888_99999999, 2'd1, 5'd5, 128'h0, 1'b0, 1'b0, 4'd9}, // R9
        '{1'b1, 1'b0, 2'd0, 5'd0,  128'h0, 2'd1, 5'd7, 128'h88888888_99999999, 1'b0, 1'b0, 4'd9},           // R9
        '{1'b1, 1'b0, 2'd0, 5'd0,  128'h0, 2'd2, 5'd2, 128'h0, 1'b1, 1'b0, 4'd9},                           // R9
        '{1'b1, 1'b1, 2'd0, 5'd31, 128'h5A5A5A5A, 2'd0, 5'd31, 128'h0, 1'b0, 1'b0, 4'd10},                  // R10
        '{1'b0, 1'b0, 2'd0, 5'd0,  128'h0, 2'd1, 5'd30, 128'h5A5A5A5A, 1'b0, 1'b0, 4'd10},                  // R10
        '{1'b1, 1'b0, 2'd0, 5'd0,  128'h0, 2'd1, 5'd31, 128'h0, 1'b0, 1'b0, 4'd10},                         // R10
        '{1'b0, 1'b1, 2'd3, 5'd0,  {128{1'b1}}, 2'd3, 5'd0, 128'h0, 1'b1, 1'b1, 4'd11},                     // R11
        '{1'b0, 1'b0, 2'd0, 5'd0,  128'h0, 2'd1, 5'd0, 128'h11110000_BBBB0002, 1'b0, 1'b0, 4'd11}           // R11
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         ext_mode;
    logic [1:0]   rd0_size, rd1_size, wr_size;
    logic [4:0]   rd0_idx, rd1_idx, wr_idx;
    logic [127:0] rd0_data, rd1_data, wr_data;
    logic         rd0_err, rd1_err, wr_en, wr_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_T/2) clk = ~clk;

    fprf_alias_top dut_i (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode),
        .rd0_size(rd0_size), .rd0_idx(rd0_idx), .rd0_data(rd0_data), .rd0_err(rd0_err),
        .rd1_size(rd1_size), .rd1_idx(rd1_idx), .rd1_data(rd1_data), .rd1_err(rd1_err),
        .wr_en(wr_en), .wr_size(wr_size), .wr_idx(wr_idx), .wr_data(wr_data), .wr_err(wr_err)
    );

    task automatic check(input int req, input string what, input logic [127:0] act,
                         input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ext_mode = 1'b0; wr_en = 1'b0; wr_size = 2'd0; wr_idx = '0; wr_data = '0;
        rd0_size = 2'd1; rd0_idx = '0; rd1_size = 2'd1; rd1_idx = '0;
    endtask

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: state after reset reads zero on both ports
        rd1_size = 2'd2; rd1_idx = 5'd28;
        #1;
        check(1, "reset rd0 double 0", rd0_data, '0);
        check(1, "reset rd1 quad 28", rd1_data, '0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ext_mode = VECS[i].ext;
            wr_en    = VECS[i].wen;
            wr_size  = VECS[i].wsz;
            wr_idx   = VECS[i].widx;
            wr_data  = VECS[i].wdat;
            rd0_size = VECS[i].rsz;
            rd0_idx  = VECS[i].ridx;
            #1;
            check(VECS[i].req, $sformatf("vec %0d data", i), rd0_data, VECS[i].exp_d);
            check(VECS[i].req, $sformatf("vec %0d rd err", i), 128'(rd0_err), 128'(VECS[i].exp_re));
            check(VECS[i].req, $sformatf("vec %0d wr err", i), 128'(wr_err), 128'(VECS[i].exp_we));
        end

        // R12: both read ports at once, different widths and places
        @(negedge clk);
        idle_inputs();
        rd0_size = 2'd1; rd0_idx = 5'd2;
        rd1_size = 2'd0; rd1_idx = 5'd0;
        #1;
        check(12, "dual read port 0", rd0_data, 128'h0123456789ABCDEF);
        check(12, "dual read port 1", rd1_data, 128'h11110000);
        check(12, "dual read port 1 err", 128'(rd1_err), 128'd0);

        // R1: one reset edge clears written data
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd0_size = 2'd1; rd0_idx = 5'd0;
        rd1_size = 2'd1; rd1_idx = 5'd1; ext_mode = 1'b1;
        #1;
        check(1, "after reset base double 0", rd0_data, '0);
        check(1, "after reset ext double 16", rd1_data, '0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule